// File: doc/BRIEF.md
# External Interrupt Recognition Prioritizer

This block sits between the external request pins of an x86-style core and its retirement logic. It decides which external request the core recognizes and when. Four requests are edge-triggered and are held in pending flags until they are taken: cache flush, system-management interrupt, init and non-maskable interrupt. The other four are level-sensitive and are sampled live at the moment of decision: machine-check bus error, run/stop, maskable interrupt and stop-clock. A request is recognized only at an instruction retirement boundary, and only when several conditions allow it. A software exception must not be pending. The retiring instruction must not be a stack-segment load. The write buffer must be empty if a bus cycle is in flight. At most one request is taken per boundary. Any lower-priority request stays pending for a later boundary.

A take produces a one-cycle strobe. The strobe carries the source code, the vector and, for the system-management interrupt, the entry address. The block keeps an SMM flag. While that flag is set, new system-management requests are held back, but every other source can still be recognized. A run/stop or stop-clock take has no vector. It stalls recognition until the pin that caused it is released.

A two-state control machine governs recognition. ST_RUN is the normal state, in which a boundary may be taken. ST_PAUSE is entered on the "stall entry" transition, which is the take of a run/stop or stop-clock request. ST_PAUSE returns to ST_RUN on the "stall release" transition, which happens when the pin that caused the stall is low.

Top module: `xreq_recognizer`

## Requirements
- R1: Among eligible requests the lowest source code wins. The codes are: 0 bus error, 1 run/stop, 2 flush, 3 SMI, 4 init, 5 NMI, 6 INTR, 7 stop-clock. A software exception at the boundary (`sw_exc`=1) blocks every take.
- R2: A rising edge on `flush_req`, `smi_req`, `init_req` or `nmi_req` sets a pending flag. The flag stays set until its take, which clears it. Several edges before one take give a single take.
- R3: `buschk`, `rs_req`, `intr_req` and `stpclk_req` are not stored. A level that drops before a boundary is never taken.
- R4: A take happens only on a clock where `retire`=1. `take` and its fields appear in the register stage one clock later. While `take`=0, all fields read 0.
- R5: When `bus_busy`=1 and `wbuf_empty`=0, a boundary takes nothing.
- R6: A boundary whose retiring instruction loads the stack segment (`retire_ss_load`=1) takes nothing. Pending requests are kept for the next boundary.
- R7: An SMI take sets `in_smm`. While `in_smm`=1, a pending SMI is not taken, and init and NMI still are. A pulse on `smm_exit` clears `in_smm`, and a held SMI is then taken at the next boundary.
- R8: `take_vec` is 18 for bus error, 2 for NMI, `intr_vec` for INTR and 0 otherwise. `take_entry` is `smm_base` plus 0x8000 for SMI and 0 otherwise.
- R9: The bus error request is eligible only while `mce`=1. When `mce`=0 it is ignored and a lower request is taken instead.
- R10: A run/stop or stop-clock take raises `paused`. While `paused`=1, no take occurs. `paused` drops on the clock after the causing pin is low.
- R11: Each boundary gives at most one take. After it, the other pending edge requests remain pending.
- R12: After reset, `take`, `in_smm` and `paused` are 0 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire | input | 1 | Instruction retirement boundary this clock |
| retire_ss_load | input | 1 | Retiring instruction loads the stack segment |
| sw_exc | input | 1 | Software exception pending at this boundary |
| bus_busy | input | 1 | A bus cycle is in progress |
| wbuf_empty | input | 1 | Write buffer is empty |
| mce | input | 1 | Machine-check enable control bit |
| buschk | input | 1 | Bus error request, level |
| rs_req | input | 1 | Run/stop request, level |
| flush_req | input | 1 | Cache flush request, edge |
| smi_req | input | 1 | System-management interrupt, edge |
| init_req | input | 1 | Init request, edge |
| nmi_req | input | 1 | Non-maskable interrupt, edge |
| intr_req | input | 1 | Maskable interrupt, level |
| stpclk_req | input | 1 | Stop-clock request, level |
| intr_vec | input | VW | Externally supplied INTR vector |
| smm_base | input | AW | SMM base address |
| smm_exit | input | 1 | Pulse on leaving SMM |
| take | output | 1 | One-cycle recognition strobe |
| take_src | output | 3 | Source code of the taken request |
| take_vec | output | VW | Vector of the taken request |
| take_entry | output | AW | Entry address (SMI only) |
| in_smm | output | 1 | Core is in SMM |
| paused | output | 1 | Stalled by run/stop or stop-clock |

## Verification
A pending flag that is lost or stuck shows at the ports within one boundary. A lost flag means a missing take. A stuck flag means the same source is taken again at the next boundary even though no new edge arrived. A wrong SMM flag shows on `in_smm` itself the clock after the SMI take or the exit pulse. It also decides whether a later SMI is taken or held. A control machine stuck in ST_PAUSE shows as `paused` staying high and all takes stopping. One that never enters ST_PAUSE shows as a take at the very next boundary while the stall pin is still high.

// File: rtl/xreq_pkg.sv
package xreq_pkg;
    typedef enum logic [2:0] {
        SRC_BUSCHK  = 3'd0,
        SRC_RUNSTOP = 3'd1,
        SRC_FLUSH   = 3'd2,
        SRC_SMI     = 3'd3,
        SRC_INIT    = 3'd4,
        SRC_NMI     = 3'd5,
        SRC_INTR    = 3'd6,
        SRC_STPCLK  = 3'd7
    } src_e;

    localparam int NSRC  = 8;
    localparam int NEDGE = 4;

    // bit positions inside the edge-latch vector
    localparam int E_FLUSH = 0;
    localparam int E_SMI   = 1;
    localparam int E_INIT  = 2;
    localparam int E_NMI   = 3;

    localparam int VEC_BUSERR = 18;
    localparam int VEC_NMI    = 2;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_PAUSE = 1'b1
    } ctl_e;
endpackage

// File: rtl/xreq_edge_latch.sv
module xreq_edge_latch #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_in,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic prev_q;
        logic pend_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                prev_q <= req_in[g];
                pend_q <= (pend_q & ~clr[g]) | (req_in[g] & ~prev_q);
            end
        end
        assign pend[g] = pend_q;
    end
endmodule

// File: rtl/xreq_pick.sv
module xreq_pick #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [N-1:0] grant;

    for (genvar g = 0; g < N; g++) begin : g_gr
        if (g == 0) begin : g_top
            assign grant[g] = req[g];
        end else begin : g_rest
            assign grant[g] = req[g] & ~(|req[g-1:0]);
        end
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IW'(i);
        end
    end

    assign found = |req;
endmodule

// File: rtl/xreq_recognizer.sv
module xreq_recognizer
    import xreq_pkg::*;
#(
    parameter int AW      = 32,
    parameter int VW      = 8,
    parameter int SMM_OFS = 32'h8000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          retire,
    input  logic          retire_ss_load,
    input  logic          sw_exc,
    input  logic          bus_busy,
    input  logic          wbuf_empty,
    input  logic          mce,
    input  logic          buschk,
    input  logic          rs_req,
    input  logic          flush_req,
    input  logic          smi_req,
    input  logic          init_req,
    input  logic          nmi_req,
    input  logic          intr_req,
    input  logic          stpclk_req,
    input  logic [VW-1:0] intr_vec,
    input  logic [AW-1:0] smm_base,
    input  logic          smm_exit,
    output logic          take,
    output logic [2:0]    take_src,
    output logic [VW-1:0] take_vec,
    output logic [AW-1:0] take_entry,
    output logic          in_smm,
    output logic          paused
);
    ctl_e state_q, state_n;
    logic stall_by_stp_q;
    logic in_smm_q;

    logic [NEDGE-1:0] edge_in, edge_clr, edge_pend;
    logic [NSRC-1:0]  elig;
    logic             found, gate, fire;
    logic [2:0]       win;
    logic             stall_pin;

    assign edge_in[E_FLUSH] = flush_req;
    assign edge_in[E_SMI]   = smi_req;
    assign edge_in[E_INIT]  = init_req;
    assign edge_in[E_NMI]   = nmi_req;

    xreq_edge_latch #(.N(NEDGE)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .req_in(edge_in),
        .clr   (edge_clr),
        .pend  (edge_pend)
    );

    always_comb begin
        elig              = '0;
        elig[SRC_BUSCHK]  = buschk & mce;
        elig[SRC_RUNSTOP] = rs_req;
        elig[SRC_FLUSH]   = edge_pend[E_FLUSH];
        elig[SRC_SMI]     = edge_pend[E_SMI] & ~in_smm_q;
        elig[SRC_INIT]    = edge_pend[E_INIT];
        elig[SRC_NMI]     = edge_pend[E_NMI];
        elig[SRC_INTR]    = intr_req;
        elig[SRC_STPCLK]  = stpclk_req;
    end

    xreq_pick #(.N(NSRC)) u_pick (
        .req  (elig),
        .found(found),
        .idx  (win)
    );

    assign gate = retire & ~retire_ss_load & ~sw_exc
                & (~bus_busy | wbuf_empty) & (state_q == ST_RUN);
    assign fire = gate & found;

    always_comb begin
        edge_clr          = '0;
        edge_clr[E_FLUSH] = fire & (win == SRC_FLUSH);
        edge_clr[E_SMI]   = fire & (win == SRC_SMI);
        edge_clr[E_INIT]  = fire & (win == SRC_INIT);
        edge_clr[E_NMI]   = fire & (win == SRC_NMI);
    end

    assign stall_pin = stall_by_stp_q ? stpclk_req : rs_req;

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (fire && (win == SRC_RUNSTOP || win == SRC_STPCLK))
                    state_n = ST_PAUSE;
            end
            ST_PAUSE: begin
                if (!stall_pin) state_n = ST_RUN;
            end
            default: state_n = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q        <= ST_RUN;
            stall_by_stp_q <= 1'b0;
        end else begin
            state_q <= state_n;
            if (fire && state_q == ST_RUN)
                stall_by_stp_q <= (win == SRC_STPCLK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       in_smm_q <= 1'b0;
        else if (fire && win == SRC_SMI)  in_smm_q <= 1'b1;
        else if (smm_exit)                in_smm_q <= 1'b0;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take       <= 1'b0;
            take_src   <= '0;
            take_vec   <= '0;
            take_entry <= '0;
        end else begin
            take       <= fire;
            take_src   <= fire ? win : 3'd0;
            take_vec   <= '0;
            take_entry <= '0;
            if (fire) begin
                unique case (win)
                    SRC_BUSCHK: take_vec   <= VW'(VEC_BUSERR);
                    SRC_NMI:    take_vec   <= VW'(VEC_NMI);
                    SRC_INTR:   take_vec   <= intr_vec;
                    SRC_SMI:    take_entry <= smm_base + AW'(SMM_OFS);
                    default:    take_vec   <= '0;
                endcase
            end
        end
    end

    assign in_smm = in_smm_q;
    assign paused = (state_q == ST_PAUSE);
endmodule

// File: rtl/xreq_recognizer_chk.sv
module xreq_recognizer_chk #(
    parameter int VW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          retire,
    input logic          retire_ss_load,
    input logic          sw_exc,
    input logic          bus_busy,
    input logic          wbuf_empty,
    input logic          mce,
    input logic          take,
    input logic [2:0]    take_src,
    input logic [VW-1:0] take_vec,
    input logic          in_smm,
    input logic          paused,
    input logic          smm_exit
);
    a_r4_take_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(retire));

    a_r6_ss_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !$past(retire_ss_load));

    a_r5_wbuf_gate: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (!$past(bus_busy) || $past(wbuf_empty)));

    a_r1_sw_exc_first: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !$past(sw_exc));

    a_r7_smi_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_src == 3'd3) |-> !$past(in_smm));

    a_r7_smm_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(smm_exit) && !(take && take_src == 3'd3)) |-> !in_smm);

    a_r9_mce_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_src == 3'd0) |-> $past(mce));

    a_r8_nmi_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_src == 3'd5) |-> take_vec == VW'(2));

    a_r10_paused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(paused) |-> !take);
endmodule

bind xreq_recognizer xreq_recognizer_chk #(.VW(VW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .retire        (retire),
    .retire_ss_load(retire_ss_load),
    .sw_exc        (sw_exc),
    .bus_busy      (bus_busy),
    .wbuf_empty    (wbuf_empty),
    .mce           (mce),
    .take          (take),
    .take_src      (take_src),
    .take_vec      (take_vec),
    .in_smm        (in_smm),
    .paused        (paused),
    .smm_exit      (smm_exit)
);

// File: tb/xreq_recognizer_tb.sv
module xreq_recognizer_tb;
    localparam int AW = 32;
    localparam int VW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic retire = 0, retire_ss_load = 0, sw_exc = 0, bus_busy = 0, wbuf_empty = 1, mce = 0;
    logic buschk = 0, rs_req = 0, flush_req = 0, smi_req = 0, init_req = 0, nmi_req = 0;
    logic intr_req = 0, stpclk_req = 0, smm_exit = 0;
    logic [VW-1:0] intr_vec = 8'h5A;
    logic [AW-1:0] smm_base = 32'h0003_0000;
    logic          take;
    logic [2:0]    take_src;
    logic [VW-1:0] take_vec;
    logic [AW-1:0] take_entry;
    logic          in_smm, paused;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    xreq_recognizer #(.AW(AW), .VW(VW)) u_dut (
        .clk(clk), .rst_n(rst_n), .retire(retire), .retire_ss_load(retire_ss_load),
        .sw_exc(sw_exc), .bus_busy(bus_busy), .wbuf_empty(wbuf_empty), .mce(mce),
        .buschk(buschk), .rs_req(rs_req), .flush_req(flush_req), .smi_req(smi_req),
        .init_req(init_req), .nmi_req(nmi_req), .intr_req(intr_req), .stpclk_req(stpclk_req),
        .intr_vec(intr_vec), .smm_base(smm_base), .smm_exit(smm_exit),
        .take(take), .take_src(take_src), .take_vec(take_vec), .take_entry(take_entry),
        .in_smm(in_smm), .paused(paused)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic boundary();
        @(negedge clk) retire = 1'b1;
        @(negedge clk) retire = 1'b0;
    endtask

    task automatic expect_take(input string req, input int src, input int vec, input logic [31:0] ent);
        chk(req, "take", 32'(take), 32'd1);
        chk(req, "take_src", 32'(take_src), 32'(src));
        chk(req, "take_vec", 32'(take_vec), 32'(vec));
        chk(req, "take_entry", take_entry, ent);
    endtask

    task automatic expect_none(input string req);
        chk(req, "no take", 32'(take), 32'd0);
    endtask

    task automatic t_reset();
        chk("R12", "take after reset", 32'(take), 0);
        chk("R12", "in_smm after reset", 32'(in_smm), 0);
        chk("R12", "paused after reset", 32'(paused), 0);
        boundary();
        expect_none("R12");
    endtask

    task automatic t_priority();
        @(negedge clk) begin flush_req = 1; smi_req = 1; init_req = 1; nmi_req = 1; intr_req = 1; end
        @(negedge clk) begin flush_req = 0; smi_req = 0; init_req = 0; nmi_req = 0; end
        boundary(); expect_take("R1", 2, 0, 0);
        boundary(); expect_take("R8", 3, 0, 32'h0003_8000);
        chk("R7", "in_smm after SMI", 32'(in_smm), 1);
        boundary(); expect_take("R7", 4, 0, 0);
        boundary(); expect_take("R11", 5, 2, 0);
        boundary(); expect_take("R8", 6, 8'h5A, 0);
        @(negedge clk) intr_req = 0;
        boundary(); expect_none("R2");
    endtask

    task automatic t_smm_mask();
        @(negedge clk) smi_req = 1;
        @(negedge clk) smi_req = 0;
        boundary(); expect_none("R7");
        @(negedge clk) smm_exit = 1;
        @(negedge clk) smm_exit = 0;
        chk("R7", "in_smm after exit", 32'(in_smm), 0);
        boundary(); expect_take("R7", 3, 0, 32'h0003_8000);
        @(negedge clk) smm_exit = 1;
        @(negedge clk) smm_exit = 0;
    endtask

    task automatic t_level();
        @(negedge clk) intr_req = 1;
        @(negedge clk) intr_req = 0;
        boundary(); expect_none("R3");
    endtask

    task automatic t_gates();
        @(negedge clk) nmi_req = 1;
        @(negedge clk) nmi_req = 0;
        @(negedge clk) nmi_req = 1;
        @(negedge clk) nmi_req = 0;
        repeat (3) @(negedge clk);
        expect_none("R4");
        bus_busy = 1; wbuf_empty = 0;
        boundary(); expect_none("R5");
        bus_busy = 0; wbuf_empty = 1; retire_ss_load = 1;
        boundary(); expect_none("R6");
        retire_ss_load = 0; sw_exc = 1;
        boundary(); expect_none("R1");
        sw_exc = 0; bus_busy = 1;
        boundary(); expect_take("R5", 5, 2, 0);
        bus_busy = 0;
        boundary(); expect_none("R2");
    endtask

    task automatic t_buserr();
        @(negedge clk) begin buschk = 1; nmi_req = 1; end
        @(negedge clk) nmi_req = 0;
        boundary(); expect_take("R9", 5, 2, 0);
        @(negedge clk) mce = 1;
        boundary(); expect_take("R8", 0, 18, 0);
        @(negedge clk) begin buschk = 0; mce = 0; end
    endtask

    task automatic t_pause();
        @(negedge clk) rs_req = 1;
        boundary(); expect_take("R10", 1, 0, 0);
        chk("R10", "paused on run/stop", 32'(paused), 1);
        @(negedge clk) nmi_req = 1;
        @(negedge clk) nmi_req = 0;
        boundary(); expect_none("R10");
        chk("R10", "still paused", 32'(paused), 1);
        @(negedge clk) rs_req = 0;
        @(negedge clk);
        chk("R10", "pause released", 32'(paused), 0);
        boundary(); expect_take("R10", 5, 2, 0);
        @(negedge clk) stpclk_req = 1;
        boundary(); expect_take("R1", 7, 0, 0);
        chk("R10", "paused on stop-clock", 32'(paused), 1);
        @(negedge clk) stpclk_req = 0;
        @(negedge clk);
        chk("R10", "stop-clock released", 32'(paused), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_priority();
        t_smm_mask();
        t_level();
        t_gates();
        t_buserr();
        t_pause();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule